// File: doc/BRIEF.md
# Single-wire bus bit slot engine

This block drives one open-drain, single-wire bus line. It generates the basic time slots on that line: a bus reset followed by a presence sample, a write slot for a 0 or a 1, a read slot, and a touch slot. A host starts one slot at a time with a one-cycle request. The request carries the slot kind, a data bit, and a time scale factor. When the slot ends, the block returns the result bit and a one-cycle done pulse.

All slot phases are timed in microseconds. A free-running divider makes a one-cycle tick every `CLK_PER_US` clocks. The divider restarts whenever the engine is idle, so every phase boundary falls exactly on a tick. The pad is modelled as an active-high pull-low enable. The returned line level passes through a two-flop synchronizer before it is sampled.

The scale input multiplies every phase length by the same integer. This lets the engine run slow buses or long cables without any other change.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, `drive_low_o`, `busy_o` and `done_o` are 0 and `rx_bit_o` is 0.
- R2: A write slot (`slot_kind_i` = 2'b01) with `bit_i` = 1 pulls the line low for 6 µs × scale. The whole slot lasts 70 µs × scale. `rx_bit_o` reports 1.
- R3: A write slot with `bit_i` = 0 pulls the line low for 60 µs × scale. The whole slot lasts 70 µs × scale. `rx_bit_o` reports 0.
- R4: A read slot (`slot_kind_i` = 2'b10) pulls the line low for 6 µs × scale. It samples the synchronized line 9 µs × scale after release, then stays idle for another 55 µs × scale (70 µs × scale in total). `rx_bit_o` reports the sampled level. A line change after the sample instant has no effect on the result.
- R5: A reset slot (`slot_kind_i` = 2'b00) pulls the line low for 500 µs × scale. It samples 70 µs × scale after release, then waits 430 µs × scale (1000 µs × scale in total). `rx_bit_o` = 0 means a device answered; 1 means no device.
- R6: A touch slot (`slot_kind_i` = 2'b11) with `bit_i` = 1 behaves exactly as a read slot. With `bit_i` = 0 it behaves as a write-0 slot and reports 0, whatever the line does.
- R7: Every phase length is multiplied by `scale_i`, latched at acceptance. A scale of 0 is treated as 1.
- R8: `busy_o` rises in the cycle after a request is accepted while idle. It stays high until the done pulse. A request that arrives while busy is ignored and does not lengthen or start a slot.
- R9: `done_o` is a single-cycle pulse issued as `busy_o` falls. `rx_bit_o` changes only together with `done_o` and holds its value until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Slot request strobe, taken only while idle |
| slot_kind_i | input | 2 | 00 reset, 01 write, 10 read, 11 touch |
| bit_i | input | 1 | Data bit for write and touch slots |
| scale_i | input | SCALE_W | Timing multiplier, 0 treated as 1 |
| line_i | input | 1 | Bus line level from the pad (asynchronous) |
| drive_low_o | output | 1 | Pad pull-low enable |
| busy_o | output | 1 | Slot in progress |
| done_o | output | 1 | One-cycle end-of-slot pulse |
| rx_bit_o | output | 1 | Sampled or reported bit of the last slot |

## Verification
The hardest condition to reach from the ports is the exact sample instant of a read slot. The question is whether a device edge just before that instant is seen, and whether one just after it is ignored. The synchronizer delay sits between the pin and the sample. The bench therefore models the bus as a wired-AND of the engine's pull-low and a device pull-low. It raises the device pull-low at a chosen clock count after acceptance: four cycles before the sample edge in one run, and half a cycle after it in another. The expected results are 0 and 1.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [1:0] {
        SLOT_RESET = 2'b00,
        SLOT_WRITE = 2'b01,
        SLOT_READ  = 2'b10,
        SLOT_TOUCH = 2'b11
    } slot_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    // phase lengths in microseconds
    localparam int DUR_W       = 10;
    localparam int US_W1_LOW   = 6;
    localparam int US_W1_GAP   = 64;
    localparam int US_W0_LOW   = 60;
    localparam int US_W0_GAP   = 10;
    localparam int US_RD_LOW   = 6;
    localparam int US_RD_GAP   = 9;
    localparam int US_RD_TAIL  = 55;
    localparam int US_RST_LOW  = 500;
    localparam int US_RST_GAP  = 70;
    localparam int US_RST_TAIL = 430;

endpackage

// File: rtl/owire_us_tick.sv
module owire_us_tick #(
    parameter int DIV = 125
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_d, div_q;

    assign tick_o = (div_q == LAST);

    always_comb begin
        div_d = div_q + W'(1);
        if (clear_i || tick_o) div_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end
endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign stg_d[i] = async_i;
            end else begin : g_next
                assign stg_d[i] = stg_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '1;
        else         stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/owire_slot_plan.sv
module owire_slot_plan
    import owire_pkg::*;
(
    input  slot_kind_e       kind_i,
    input  logic             bit_i,
    output logic [DUR_W-1:0] low_us_o,
    output logic [DUR_W-1:0] gap_us_o,
    output logic [DUR_W-1:0] tail_us_o,
    output logic             sample_o
);
    logic as_read;

    // a touch with 1 is a read slot; a touch with 0 is a write-0 slot
    always_comb begin
        as_read = (kind_i == SLOT_READ) || (kind_i == SLOT_TOUCH && bit_i);
        sample_o  = 1'b0;
        tail_us_o = '0;
        if (kind_i == SLOT_RESET) begin
            low_us_o  = DUR_W'(US_RST_LOW);
            gap_us_o  = DUR_W'(US_RST_GAP);
            tail_us_o = DUR_W'(US_RST_TAIL);
            sample_o  = 1'b1;
        end else if (as_read) begin
            low_us_o  = DUR_W'(US_RD_LOW);
            gap_us_o  = DUR_W'(US_RD_GAP);
            tail_us_o = DUR_W'(US_RD_TAIL);
            sample_o  = 1'b1;
        end else if (bit_i) begin
            low_us_o  = DUR_W'(US_W1_LOW);
            gap_us_o  = DUR_W'(US_W1_GAP);
        end else begin
            low_us_o  = DUR_W'(US_W0_LOW);
            gap_us_o  = DUR_W'(US_W0_GAP);
        end
    end
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
    import owire_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int SCALE_W    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic [1:0]         slot_kind_i,
    input  logic               bit_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               line_i,
    output logic               drive_low_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               rx_bit_o
);
    localparam int CNT_W = DUR_W + SCALE_W;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        slot_kind_e         kind;
        logic               bitv;
        logic [SCALE_W-1:0] scale;
        logic               smp;
        logic               rx;
        logic               done;
    } eng_t;

    eng_t st_d, st_q;

    logic             tick;
    logic             line_s;
    logic             idle;
    slot_kind_e       plan_kind;
    logic             plan_bit;
    logic [SCALE_W-1:0] scale_live;
    logic [SCALE_W-1:0] scale_use;
    logic [DUR_W-1:0] low_us, gap_us, tail_us;
    logic             plan_sample;

    assign idle       = (st_q.phase == PH_IDLE);
    assign scale_live = (scale_i == '0) ? SCALE_W'(1) : scale_i;
    assign plan_kind  = idle ? slot_kind_e'(slot_kind_i) : st_q.kind;
    assign plan_bit   = idle ? bit_i : st_q.bitv;
    assign scale_use  = idle ? scale_live : st_q.scale;

    owire_us_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (idle),
        .tick_o  (tick)
    );

    owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (line_i),
        .sync_o  (line_s)
    );

    owire_slot_plan u_plan (
        .kind_i    (plan_kind),
        .bit_i     (plan_bit),
        .low_us_o  (low_us),
        .gap_us_o  (gap_us),
        .tail_us_o (tail_us),
        .sample_o  (plan_sample)
    );

    always_comb begin
        logic last;
        logic result;
        st_d      = st_q;
        st_d.done = 1'b0;
        last      = tick && (st_q.cnt == CNT_W'(1));
        result    = plan_sample ? line_s : plan_bit;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.phase = PH_LOW;
                    st_d.kind  = slot_kind_e'(slot_kind_i);
                    st_d.bitv  = bit_i;
                    st_d.scale = scale_live;
                    st_d.cnt   = CNT_W'(low_us) * CNT_W'(scale_use);
                end
            end
            PH_LOW: begin
                if (last) begin
                    st_d.phase = PH_GAP;
                    st_d.cnt   = CNT_W'(gap_us) * CNT_W'(scale_use);
                end else if (tick) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_GAP: begin
                if (last) begin
                    st_d.smp = result;
                    if (tail_us != '0) begin
                        st_d.phase = PH_TAIL;
                        st_d.cnt   = CNT_W'(tail_us) * CNT_W'(scale_use);
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.rx    = result;
                        st_d.done  = 1'b1;
                    end
                end else if (tick) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_TAIL: begin
                if (last) begin
                    st_d.phase = PH_IDLE;
                    st_d.rx    = st_q.smp;
                    st_d.done  = 1'b1;
                end else if (tick) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, kind: SLOT_RESET, bitv: 1'b0,
                      scale: '0, smp: 1'b0, rx: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_low_o = (st_q.phase == PH_LOW);
    assign busy_o      = !idle;
    assign done_o      = st_q.done;
    assign rx_bit_o    = st_q.rx;
endmodule

// File: rtl/owire_slot_chk.sv
module owire_slot_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_i,
    input logic drive_low_o,
    input logic busy_o,
    input logic done_o,
    input logic rx_bit_o
);
    // R9
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R8
    no_spurious_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !req_i) |=> !busy_o);

    // R8
    busy_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    // R2
    drive_in_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_low_o |-> busy_o);

    // R9
    rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(rx_bit_o));
endmodule

bind owire_slot_engine owire_slot_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .drive_low_o (drive_low_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rx_bit_o    (rx_bit_o)
);

// File: tb/sim_owire_slot_engine.sv
`timescale 1ns/1ps
module sim_owire_slot_engine;
    localparam int C  = 2;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [1:0] kind = 2'b00;
    logic bitv = 1'b0;
    logic [SW-1:0] scale = 4'd1;
    logic dev_low = 1'b0;
    logic line;
    logic drive_low, busy, done, rx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    assign line = !(drive_low || dev_low);

    always #4 clk = ~clk;

    owire_slot_engine #(.CLK_PER_US(C), .SCALE_W(SW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .slot_kind_i(kind),
        .bit_i(bitv), .scale_i(scale), .line_i(line),
        .drive_low_o(drive_low), .busy_o(busy), .done_o(done), .rx_bit_o(rx)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic        b;
        logic [3:0]  scale;
        logic        dev;
        logic [15:0] low_us;
        logic [15:0] tot_us;
        logic        rx;
        logic [7:0]  req_id;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 1'b1, 4'd1, 1'b0, 16'd6,   16'd70,   1'b1, 8'd2},
        '{2'b01, 1'b0, 4'd1, 1'b0, 16'd60,  16'd70,   1'b0, 8'd3},
        '{2'b10, 1'b0, 4'd1, 1'b0, 16'd6,   16'd70,   1'b1, 8'd4},
        '{2'b10, 1'b0, 4'd1, 1'b1, 16'd6,   16'd70,   1'b0, 8'd4},
        '{2'b00, 1'b0, 4'd1, 1'b1, 16'd500, 16'd1000, 1'b0, 8'd5},
        '{2'b00, 1'b0, 4'd1, 1'b0, 16'd500, 16'd1000, 1'b1, 8'd5},
        '{2'b11, 1'b1, 4'd1, 1'b1, 16'd6,   16'd70,   1'b0, 8'd6},
        '{2'b11, 1'b0, 4'd1, 1'b0, 16'd60,  16'd70,   1'b0, 8'd6},
        '{2'b01, 1'b1, 4'd3, 1'b0, 16'd18,  16'd210,  1'b1, 8'd7},
        '{2'b10, 1'b0, 4'd2, 1'b0, 16'd12,  16'd140,  1'b1, 8'd7},
        '{2'b01, 1'b0, 4'd0, 1'b0, 16'd60,  16'd70,   1'b0, 8'd7},
        '{2'b00, 1'b0, 4'd2, 1'b1, 16'd1000,16'd2000, 1'b0, 8'd7}
    };

    task automatic check(input string req_name, input string what,
                         input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req_name, what, act, exp);
        end
    endtask

    function automatic string rname(input int id);
        case (id)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    // start a slot; dev_at: negedge count at which the device pulls low (-1 never)
    // stray_at: negedge count at which a second request is issued (-1 never)
    task automatic run_slot(input logic [1:0] k, input logic b, input logic [3:0] s,
                            input int dev_at, input int stray_at,
                            output int lowc, output int total, output logic r,
                            output logic busy_at_done, output logic done_next);
        @(negedge clk);
        req = 1'b1; kind = k; bitv = b; scale = s;
        dev_low = (dev_at == 0);
        @(negedge clk);
        req = 1'b0;
        total = 1;
        lowc = drive_low ? 1 : 0;
        while (!done && total < 50000) begin
            @(negedge clk);
            total++;
            if (total == dev_at) dev_low = 1'b1;
            if (total == stray_at) begin
                req = 1'b1; kind = 2'b00; bitv = 1'b1;
            end else begin
                req = 1'b0;
            end
            if (drive_low) lowc++;
        end
        r = rx;
        busy_at_done = busy;
        @(negedge clk);
        done_next = done;
        dev_low = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_fail++;
                $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 0);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        int lowc, total;
        logic r, bz, dn;
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held and just after release
        check("R1", "drive_low in reset", drive_low, 0);
        check("R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", done, 0);
        check("R1", "rx after reset", rx, 0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            int sc;
            rq = rname(int'(VECS[i].req_id));
            sc = (VECS[i].scale == 0) ? 1 : int'(VECS[i].scale);
            run_slot(VECS[i].kind, VECS[i].b, VECS[i].scale,
                     VECS[i].dev ? 0 : -1, -1, lowc, total, r, bz, dn);
            check(rq, $sformatf("vec%0d low cycles", i), lowc, int'(VECS[i].low_us) * C);
            check(rq, $sformatf("vec%0d slot cycles", i), total, int'(VECS[i].tot_us) * C + 1);
            check(rq, $sformatf("vec%0d rx", i), r, VECS[i].rx);
            check("R9", $sformatf("vec%0d busy at done", i), bz, 0);
            check("R9", $sformatf("vec%0d done width", i), dn, 0);
            if (sc == 0) n_fail++;
        end

        // R4: device pulls low 4 cycles before the sample edge -> seen
        run_slot(2'b10, 1'b0, 4'd1, 27, -1, lowc, total, r, bz, dn);
        check("R4", "early device low sampled", r, 0);
        // R4: device pulls low half a cycle after the sample edge -> ignored
        run_slot(2'b10, 1'b0, 4'd1, 31, -1, lowc, total, r, bz, dn);
        check("R4", "late device low ignored", r, 1);
        check("R4", "late case slot cycles", total, 70 * C + 1);

        // R8: a reset request in the middle of a write-0 slot is ignored
        run_slot(2'b01, 1'b0, 4'd1, -1, 10, lowc, total, r, bz, dn);
        check("R8", "slot length with stray request", total, 70 * C + 1);
        check("R8", "low length with stray request", lowc, 60 * C);
        begin
            int seen = 0;
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                if (drive_low || busy) seen++;
            end
            check("R8", "no slot started by stray request", seen, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule